// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which of five interrupt sources a small 8-bit processor core services next. The sources are a non-maskable trap, three auto-vectored restart inputs (high, mid and low) and one general request that is vectored by external logic. The controller holds a software interrupt-enable flag and three per-restart mask bits. It keeps a pending latch for the edge-triggered high restart, and it qualifies the trap so that it needs an edge followed by a held level.

The core raises `sample_stb` in the next-to-last clock cycle of each instruction. Requests are looked at only on that strobe. The winning source is offered on a valid/ready output that carries the restart vector address. For the general request the vector is zero, and `acc_inta` asks the core to run an acknowledge cycle, which has read-strobe timing, so that outside logic can supply the instruction. `pc_inhibit` follows `acc_valid` and holds the program-counter increment. Back-pressure rules: once `acc_valid` rises, the vector and `acc_inta` stay constant until a cycle with `acc_ready` high. Valid falls after that cycle. No new request is taken while valid is high, so a strobe that comes during that time is ignored.

Top module: `pvic_top`

## Requirements
- R1: When several requests are eligible at a strobe, the one granted is, from highest to lowest priority: trap, high restart, mid restart, low restart, general request.
- R2: The trap is granted whatever the mask bits and the enable flag are. Its acceptance leaves the enable flag unchanged.
- R3: A request is accepted only at a rising clock edge where `sample_stb` is high and `acc_valid` is low. Nothing is accepted without the strobe.
- R4: `ei_cmd` sets the enable flag and `di_cmd` clears it. Reset clears it. Accepting any maskable source clears it, and that clear wins over an `ei_cmd` in the same cycle. The flag is visible at `stat_o[3]`. The three restarts and the general request are eligible only while the flag is set.
- R5: Accepting the general request presents vector 0x0000 with `acc_inta` high. `pc_inhibit` is high for every accepted source while `acc_valid` is high.
- R6: The vectors are: trap 0x0024, high restart 0x003C, mid restart 0x0034, low restart 0x002C. For all of these `acc_inta` is low.
- R7: A rising edge on `rst75_in` sets a pending latch (`stat_o[6]`). The latch is set even while the source is masked. It is cleared only by servicing that source or by a mask write with `clr75` high.
- R8: The mid and low restarts and the general request are level-sensitive. A restart whose mask bit is 1 is not granted.
- R9: The trap is granted only if a rising edge on `trap_in` is followed by a high level that lasts until the strobe. A trap held high is serviced only once. A pulse that ends before the strobe is not serviced.
- R10: A mask write loads `mask_val` into the mask bits: bit0 masks the low restart, bit1 the mid restart, bit2 the high restart. `stat_o` is {trap armed, high pending, mid level, low level, enable, mask[2:0]} from bit 7 down to bit 0.
- R11: While `acc_valid` is high and `acc_ready` is low, `acc_valid`, `acc_vector` and `acc_inta` hold. After a cycle with `acc_ready` high, `acc_valid` is low.
- R12: After reset, `acc_valid` is 0, all mask bits are 1, the enable flag is 0 and no latch is pending (`stat_o` = 0x07).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_in | input | 1 | Non-maskable trap request |
| rst75_in | input | 1 | High restart request, edge-triggered |
| rst65_in | input | 1 | Mid restart request, level |
| rst55_in | input | 1 | Low restart request, level |
| intr_in | input | 1 | General request, externally vectored |
| sample_stb | input | 1 | Core strobe marking the next-to-last cycle of an instruction |
| ei_cmd | input | 1 | Set the enable flag |
| di_cmd | input | 1 | Clear the enable flag |
| mask_wr | input | 1 | Mask write strobe |
| mask_val | input | 3 | New mask bits |
| clr75 | input | 1 | With mask_wr: clear the high-restart pending latch |
| acc_valid | output | 1 | Accepted interrupt offered |
| acc_ready | input | 1 | Core takes the offered interrupt |
| acc_vector | output | 16 | Restart address, 0 for the general request |
| acc_inta | output | 1 | Acknowledge cycle needed (general request) |
| pc_inhibit | output | 1 | Hold the program-counter increment |
| stat_o | output | 8 | Status: trap armed, pending, levels, enable, mask |

## Verification
Two pairs of actions can land on the same edge. First, the clear of the enable flag caused by an acceptance can meet an `ei_cmd`. The bench raises `ei_cmd` on the strobe cycle that accepts the general request, and it expects `stat_o[3]` to read 0 afterwards. Second, a new strobe can arrive while an earlier acceptance is still held by back-pressure. The bench strobes with a fresh request pending while `acc_ready` is low. It then expects the held vector to stay unchanged and `acc_valid` to drop after the single ready cycle, with no second offer.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int NSRC  = 5;
  localparam int VEC_W = 16;
  localparam int IDX_W = $clog2(NSRC);

  // source index equals priority rank, 0 is highest
  typedef enum logic [IDX_W-1:0] {
    SRC_TRAP = 3'd0,
    SRC_HI   = 3'd1,
    SRC_MID  = 3'd2,
    SRC_LO   = 3'd3,
    SRC_GEN  = 3'd4
  } src_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    case (idx)
      SRC_TRAP: vec_of = 16'h0024;
      SRC_HI:   vec_of = 16'h003C;
      SRC_MID:  vec_of = 16'h0034;
      SRC_LO:   vec_of = 16'h002C;
      default:  vec_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/pvic_req_cond.sv
module pvic_req_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_in,
  input  logic rst75_in,
  input  logic take_trap,
  input  logic take_hi,
  input  logic clr_hi,
  output logic trap_req,
  output logic hi_pend
);
  logic trap_prev, trap_arm, hi_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_prev <= 1'b0;
      trap_arm  <= 1'b0;
      hi_prev   <= 1'b0;
      hi_pend   <= 1'b0;
    end else begin
      trap_prev <= trap_in;
      hi_prev   <= rst75_in;
      // edge arms, level must persist, service disarms
      if (!trap_in)        trap_arm <= 1'b0;
      else if (take_trap)  trap_arm <= 1'b0;
      else if (!trap_prev) trap_arm <= 1'b1;
      // a new edge wins over a same-cycle clear
      if (rst75_in && !hi_prev)  hi_pend <= 1'b1;
      else if (take_hi || clr_hi) hi_pend <= 1'b0;
    end
  end

  assign trap_req = trap_arm & trap_in;
endmodule

// File: rtl/pvic_prio.sv
module pvic_prio #(
  parameter int N = pvic_pkg::NSRC,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx
);
  logic [N-1:0] blocked;

  for (genvar i = 0; i < N; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign blocked[i] = 1'b0;
    end else begin : g_rest
      assign blocked[i] = blocked[i-1] | req[i-1];
    end
    assign grant[i] = req[i] & ~blocked[i];
  end

  always_comb begin
    idx = '0;
    for (int k = N-1; k >= 0; k--)
      if (grant[k]) idx = IW'(k);
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_in,
  input  logic             rst75_in,
  input  logic             rst65_in,
  input  logic             rst55_in,
  input  logic             intr_in,
  input  logic             sample_stb,
  input  logic             ei_cmd,
  input  logic             di_cmd,
  input  logic             mask_wr,
  input  logic [2:0]       mask_val,
  input  logic             clr75,
  output logic             acc_valid,
  input  logic             acc_ready,
  output logic [VEC_W-1:0] acc_vector,
  output logic             acc_inta,
  output logic             pc_inhibit,
  output logic [7:0]       stat_o
);
  logic             ie_q;
  logic [2:0]       mask_q;
  logic             valid_q, inta_q;
  logic [VEC_W-1:0] vec_q;
  logic             trap_req, hi_pend, take;
  logic [NSRC-1:0]  req, grant;
  logic [IDX_W-1:0] idx;

  pvic_req_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_in   (trap_in),
    .rst75_in  (rst75_in),
    .take_trap (take & grant[SRC_TRAP]),
    .take_hi   (take & grant[SRC_HI]),
    .clr_hi    (mask_wr & clr75),
    .trap_req  (trap_req),
    .hi_pend   (hi_pend)
  );

  always_comb begin
    req          = '0;
    req[SRC_TRAP] = trap_req;
    req[SRC_HI]   = hi_pend  & ~mask_q[2] & ie_q;
    req[SRC_MID]  = rst65_in & ~mask_q[1] & ie_q;
    req[SRC_LO]   = rst55_in & ~mask_q[0] & ie_q;
    req[SRC_GEN]  = intr_in  & ie_q;
  end

  pvic_prio #(.N(NSRC)) u_prio (
    .req   (req),
    .grant (grant),
    .idx   (idx)
  );

  assign take = sample_stb & ~valid_q & (|req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      mask_q  <= 3'b111;
      valid_q <= 1'b0;
      inta_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      if (take && !grant[SRC_TRAP]) ie_q <= 1'b0;
      else if (di_cmd)              ie_q <= 1'b0;
      else if (ei_cmd)              ie_q <= 1'b1;
      if (mask_wr) mask_q <= mask_val;
      if (take) begin
        valid_q <= 1'b1;
        vec_q   <= vec_of(idx);
        inta_q  <= grant[SRC_GEN];
      end else if (acc_ready) begin
        valid_q <= 1'b0;
        inta_q  <= 1'b0;
      end
    end
  end

  assign acc_valid  = valid_q;
  assign acc_vector = vec_q;
  assign acc_inta   = inta_q;
  assign pc_inhibit = valid_q;
  assign stat_o     = {trap_req, hi_pend, rst65_in, rst55_in, ie_q, mask_q};
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_stb,
  input logic        acc_valid,
  input logic        acc_ready,
  input logic [15:0] acc_vector,
  input logic        acc_inta,
  input logic        ie,
  input logic        trap_req
);
  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb && !acc_valid && trap_req |=> acc_valid && acc_vector == 16'h0024); // R2
  AST_IE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_valid) && acc_vector != 16'h0024 |-> !ie); // R4
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_vector) && $stable(acc_inta)); // R11
  AST_INTA_ZERO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_inta |-> acc_valid && acc_vector == 16'h0000); // R5
  AST_NO_STROBE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb && !acc_valid |=> !acc_valid); // R3
endmodule

bind pvic_top pvic_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_vector (acc_vector),
  .acc_inta   (acc_inta),
  .ie         (stat_o[3]),
  .trap_req   (trap_req)
);

// File: tb/sim_pvic_top.sv
module sim_pvic_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic trap_in = 0, rst75_in = 0, rst65_in = 0, rst55_in = 0, intr_in = 0;
  logic sample_stb = 0, ei_cmd = 0, di_cmd = 0, mask_wr = 0, clr75 = 0, acc_ready = 0;
  logic [2:0] mask_val = 0;
  logic acc_valid, acc_inta, pc_inhibit;
  logic [15:0] acc_vector;
  logic [7:0] stat_o;
  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pvic_top u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic ei(); ei_cmd = 1; step(); ei_cmd = 0; endtask
  task automatic di(); di_cmd = 1; step(); di_cmd = 0; endtask
  task automatic wmask(input logic [2:0] m, input logic c);
    mask_wr = 1; mask_val = m; clr75 = c; step(); mask_wr = 0; clr75 = 0;
  endtask
  task automatic strobe(); sample_stb = 1; step(); sample_stb = 0; endtask
  task automatic release_acc(); acc_ready = 1; step(); acc_ready = 0; endtask

  task automatic t_reset();
    chk("R12 status", stat_o, 8'h07);
    chk("R12 valid", acc_valid, 0);
    ei(); chk("R4 ei sets", stat_o[3], 1);
    di(); chk("R4 di clears", stat_o[3], 0);
  endtask

  task automatic t_general();
    ei(); intr_in = 1;
    repeat (5) step();
    chk("R3 no strobe", acc_valid, 0);
    strobe();
    chk("R5 valid", acc_valid, 1);
    chk("R5 vector", acc_vector, 16'h0000);
    chk("R5 inta", acc_inta, 1);
    chk("R5 inhibit", pc_inhibit, 1);
    chk("R4 cleared on take", stat_o[3], 0);
    release_acc(); intr_in = 0;
    chk("R11 valid drops", acc_valid, 0);
  endtask

  task automatic t_levels();
    wmask(3'b000, 0); ei(); rst65_in = 1; strobe();
    chk("R6 mid vector", acc_vector, 16'h0034);
    chk("R6 mid no inta", acc_inta, 0);
    release_acc(); rst65_in = 0;
    ei(); rst55_in = 1; strobe();
    chk("R6 low vector", acc_vector, 16'h002C);
    chk("R8 low taken", acc_valid, 1);
    release_acc(); rst55_in = 0;
  endtask

  task automatic t_mask();
    wmask(3'b001, 0);
    chk("R10 mask field", stat_o[2:0], 3'b001);
    ei(); rst55_in = 1; step();
    chk("R10 low level bit", stat_o[4], 1);
    strobe();
    chk("R8 masked low ignored", acc_valid, 0);
    rst55_in = 0; wmask(3'b000, 0);
  endtask

  task automatic t_priority();
    ei(); rst65_in = 1; rst55_in = 1; intr_in = 1;
    rst75_in = 1; step(); rst75_in = 0;
    strobe(); chk("R1 high first", acc_vector, 16'h003C);
    release_acc(); ei(); strobe();
    chk("R1 mid second", acc_vector, 16'h0034);
    release_acc(); ei(); rst65_in = 0; strobe();
    chk("R1 low third", acc_vector, 16'h002C);
    release_acc(); ei(); rst55_in = 0; strobe();
    chk("R1 general last", acc_inta, 1);
    release_acc(); intr_in = 0;
  endtask

  task automatic t_hi_latch();
    wmask(3'b100, 0);
    rst75_in = 1; step(); rst75_in = 0;
    chk("R7 pending set while masked", stat_o[6], 1);
    ei(); strobe();
    chk("R7 masked not taken", acc_valid, 0);
    chk("R7 still pending", stat_o[6], 1);
    wmask(3'b000, 1);
    chk("R7 cleared by write", stat_o[6], 0);
    strobe();
    chk("R7 cleared not taken", acc_valid, 0);
    rst75_in = 1; step(); rst75_in = 0; strobe();
    chk("R7 serviced vector", acc_vector, 16'h003C);
    chk("R7 pending cleared", stat_o[6], 0);
    release_acc();
  endtask

  task automatic t_trap();
    wmask(3'b111, 0); ei();
    trap_in = 1; step();
    chk("R10 trap armed bit", stat_o[7], 1);
    strobe();
    chk("R2 trap vector", acc_vector, 16'h0024);
    chk("R2 enable kept", stat_o[3], 1);
    release_acc(); strobe();
    chk("R9 once per assertion", acc_valid, 0);
    trap_in = 0; step();
    trap_in = 1; step(); trap_in = 0; strobe();
    chk("R9 short pulse ignored", acc_valid, 0);
    di();
    trap_in = 1; step(); strobe();
    chk("R2 trap with enable off", acc_vector, 16'h0024);
    release_acc(); trap_in = 0; step();
  endtask

  task automatic t_collide();
    wmask(3'b000, 0); ei(); intr_in = 1;
    ei_cmd = 1; sample_stb = 1; step(); ei_cmd = 0; sample_stb = 0;
    chk("R4 take beats ei", stat_o[3], 0);
    ei(); rst55_in = 1;
    repeat (3) step();
    chk("R11 held valid", acc_valid, 1);
    chk("R11 held vector", acc_vector, 16'h0000);
    strobe();
    chk("R11 strobe while held", acc_inta, 1);
    release_acc();
    chk("R11 single offer", acc_valid, 0);
    intr_in = 0; rst55_in = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset(); t_general(); t_levels(); t_mask(); t_priority();
    t_hi_latch(); t_trap(); t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; errs++;
        $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule